// File: doc/BRIEF.md
# Serial Management Register Slave for a Gigabit PCS

This block sits beside a gigabit physical coding sublayer and answers the two-wire serial management bus (a clock line and a bidirectional data line). It decodes read and write frames in the Clause 22 format. Writes update the few writable control fields. Reads return a fixed gigabit full-duplex register set, mixed with live and latched status taken from the PCS. The data line is driven through a separate output value and output enable, so a pad tri-state buffer can be placed outside the block.

The management clock is not used as a clock. It is sampled through a synchronizer in the system clock domain, and each bit is taken on its rising edge. The block drives four commands to the PCS: reset, loopback, auto-negotiation enable and auto-negotiation restart. Reset and restart are single-cycle pulses. The auto-negotiation engine itself is not part of this block. That engine provides link, fault, completion, partner-ability and page inputs, and these appear in the status registers.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: The block accepts a frame only when its 5-bit PHY address field equals `phyAddr`. For any other address it never asserts `mdioOe` and no register changes.
- R2: A read frame is handled in this order. `mdioOe` stays low for the first turnaround bit. The block then drives 0 for the second turnaround bit. Next it drives the 16 data bits MSB first, each one changing after a rising MDC edge. It releases the line (`mdioOe`=0, `mdioOut`=0) after the last data bit.
- R3: Control (address 0) resets to 0x0140. Bit 14 (loopback) and bit 12 (auto-negotiation enable) are writable and drive `pcsLoopback` and `anEnable`. Bit 8 and bit 6 always read 1, and bit 13 always reads 0. Bits 11, 10, 7 and 5..0 read 0, and writes to them have no effect.
- R4: Writing 1 to control bit 15 does three things. It pulses `pcsReset` for exactly one cycle, returns loopback, auto-negotiation enable and the pause bits to their defaults, and bit 15 reads back 0.
- R5: Writing 1 to control bit 9 pulses `anRestart` for exactly one cycle. Bit 9 reads back 0.
- R6: Status (address 1) resets to 0x0109 and ignores writes. Bits 8, 3 and 0 always read 1. Bits 15..9, 7, 6 and 1 always read 0.
- R7: Status bit 2 latches low. It reads 0 if `linkUp` has been low at any time since the previous status read, and reads 0 after reset. Each status read reloads it from `linkUp`.
- R8: Status bit 4 latches high. It reads 1 if `remoteFault` has been high at any time since the previous status read, and each status read reloads it. Status bit 5 follows `anComplete` live.
- R9: Addresses 2 and 3 read 0x2222 and 0x3333.
- R10: Advertisement (address 4) resets to 0x0020. Bits 8:7 (pause) are writable. Bit 5 (full duplex) always reads 1, and every other bit reads 0.
- R11: Address 5 returns `partnerAbility` live. Address 6 bit 1 latches high on `pageReceived` and clears when address 6 is read. Address 15 reads 0x8000. Addresses 7..14 and 16..31 read 0.
- R12: A frame counts only if the block has seen at least 32 consecutive 1 bits before start code 01. The opcode 10 means read and 01 means write. Frames with any other opcode, or with too short a preamble, change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| phyAddr | input | 5 | PHY address this slave answers to |
| mdc | input | 1 | Management clock (asynchronous, sampled) |
| mdioIn | input | 1 | Management data line as seen at the pad |
| mdioOut | output | 1 | Value driven onto the data line |
| mdioOe | output | 1 | Output enable for the data line |
| pcsReset | output | 1 | One-cycle PCS reset pulse |
| pcsLoopback | output | 1 | PCS loopback enable |
| anEnable | output | 1 | Auto-negotiation enable |
| anRestart | output | 1 | One-cycle auto-negotiation restart pulse |
| linkUp | input | 1 | Live link status from the PCS |
| anComplete | input | 1 | Auto-negotiation complete |
| remoteFault | input | 1 | Remote fault indication |
| partnerAbility | input | 16 | Received link partner ability word |
| pageReceived | input | 1 | Page received event |

## Verification
The bench reads all 32 register addresses and compares each one with a value computed from the requirements. A decoder that aliases unmapped addresses would return nonzero data, and a wrong default would show up at its own address. For reads, it checks each turnaround slot and data bit separately. A slave that drives during the first turnaround bit, or shifts its data by one bit, fails there.

Several cases target the latching status bits. The bench drops the link briefly, raises a fault briefly, and raises a page event briefly. A design that reports live values would miss these, and one that never clears on read would keep reporting them. The remaining cases cover inputs that must be ignored: a foreign PHY address, illegal opcodes, a short preamble, and writes to read-only bits. A slave that accepts any of these would change a register value that is read back afterwards.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int DataW    = 16;
  localparam int RegAddrW = 5;
  localparam int PhyAddrW = 5;

  localparam logic [RegAddrW-1:0] AddrCtl  = 5'd0;
  localparam logic [RegAddrW-1:0] AddrSts  = 5'd1;
  localparam logic [RegAddrW-1:0] AddrIdHi = 5'd2;
  localparam logic [RegAddrW-1:0] AddrIdLo = 5'd3;
  localparam logic [RegAddrW-1:0] AddrAdv  = 5'd4;
  localparam logic [RegAddrW-1:0] AddrLpa  = 5'd5;
  localparam logic [RegAddrW-1:0] AddrExp  = 5'd6;
  localparam logic [RegAddrW-1:0] AddrExt  = 5'd15;

  // Strobes from the frame controller to the register datapath
  typedef struct packed {
    logic                rdStrobe;
    logic                wrStrobe;
    logic [RegAddrW-1:0] regAddr;
    logic [DataW-1:0]    wrData;
  } mgmtCmd_t;

  typedef enum logic [2:0] {
    ST_PRE, ST_START, ST_OPC, ST_PHY, ST_REG, ST_TA, ST_DATA
  } frameState_t;
endpackage

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl
  import mdio_pkg::*;
#(
  parameter int PRE_LEN     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [PhyAddrW-1:0] phyAddr,
  input  logic                mdc,
  input  logic                mdioIn,
  input  logic [DataW-1:0]    rdData,
  output mgmtCmd_t            cmd,
  output logic                mdioOut,
  output logic                mdioOe
);
  localparam int CntW = $clog2(PRE_LEN + 1);
  localparam logic [CntW-1:0] PreMax = CntW'(PRE_LEN);

  logic [SYNC_STAGES:0]   mdcSync;
  logic [SYNC_STAGES-1:0] mdioSync;
  logic                   mdcRise;
  logic                   sBit;

  always_ff @(posedge clk) begin
    if (rst) begin
      mdcSync  <= '0;
      mdioSync <= '0;
    end else begin
      mdcSync  <= {mdcSync[SYNC_STAGES-1:0], mdc};
      mdioSync <= {mdioSync[SYNC_STAGES-2:0], mdioIn};
    end
  end

  assign mdcRise = mdcSync[SYNC_STAGES-1] & ~mdcSync[SYNC_STAGES];
  assign sBit    = mdioSync[SYNC_STAGES-1];

  frameState_t         state;
  logic [CntW-1:0]     preCnt;
  logic [3:0]          bitCnt;
  logic [1:0]          opReg;
  logic [PhyAddrW-1:0] phyReg;
  logic [RegAddrW-1:0] regReg;
  logic [RegAddrW-1:0] regNext;
  logic [DataW-1:0]    dataSh;
  logic                isRead;
  logic                isWrite;
  logic                addrHit;

  assign regNext = {regReg[RegAddrW-2:0], sBit};
  assign addrHit = (phyReg == phyAddr);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_PRE;
      preCnt  <= '0;
      bitCnt  <= '0;
      opReg   <= '0;
      phyReg  <= '0;
      regReg  <= '0;
      dataSh  <= '0;
      isRead  <= 1'b0;
      isWrite <= 1'b0;
      mdioOut <= 1'b0;
      mdioOe  <= 1'b0;
      cmd     <= '0;
    end else begin
      cmd.rdStrobe <= 1'b0;
      cmd.wrStrobe <= 1'b0;
      // read snapshot, taken in the cycle the datapath sees the strobe
      if (cmd.rdStrobe) dataSh <= rdData;
      if (mdcRise) begin
        unique case (state)
          ST_PRE: begin
            if (sBit) begin
              if (preCnt != PreMax) preCnt <= preCnt + 1'b1;
            end else begin
              if (preCnt == PreMax) state <= ST_START;
              preCnt <= '0;
            end
          end
          ST_START: begin
            bitCnt <= '0;
            state  <= sBit ? ST_OPC : ST_PRE;
          end
          ST_OPC: begin
            opReg <= {opReg[0], sBit};
            if (bitCnt == 4'd1) begin
              bitCnt <= '0;
              state  <= ST_PHY;
            end else bitCnt <= bitCnt + 1'b1;
          end
          ST_PHY: begin
            phyReg <= {phyReg[PhyAddrW-2:0], sBit};
            if (bitCnt == 4'd4) begin
              bitCnt <= '0;
              state  <= ST_REG;
            end else bitCnt <= bitCnt + 1'b1;
          end
          ST_REG: begin
            regReg <= regNext;
            if (bitCnt == 4'd4) begin
              bitCnt  <= '0;
              state   <= ST_TA;
              isRead  <= addrHit && (opReg == 2'b10);
              isWrite <= addrHit && (opReg == 2'b01);
              if (addrHit && (opReg == 2'b10)) begin
                cmd.rdStrobe <= 1'b1;
                cmd.regAddr  <= regNext;
              end
            end else bitCnt <= bitCnt + 1'b1;
          end
          ST_TA: begin
            if (bitCnt == 4'd0) begin
              bitCnt <= 4'd1;
              if (isRead) begin
                mdioOe  <= 1'b1;
                mdioOut <= 1'b0;
              end
            end else begin
              bitCnt <= '0;
              state  <= ST_DATA;
              if (isRead) mdioOut <= dataSh[DataW-1];
            end
          end
          ST_DATA: begin
            dataSh <= {dataSh[DataW-2:0], sBit};
            if (isRead) mdioOut <= dataSh[DataW-2];
            if (bitCnt == 4'(DataW - 1)) begin
              state   <= ST_PRE;
              preCnt  <= '0;
              bitCnt  <= '0;
              mdioOe  <= 1'b0;
              mdioOut <= 1'b0;
              isRead  <= 1'b0;
              isWrite <= 1'b0;
              if (isWrite) begin
                cmd.wrStrobe <= 1'b1;
                cmd.regAddr  <= regReg;
                cmd.wrData   <= {dataSh[DataW-2:0], sBit};
              end
            end else bitCnt <= bitCnt + 1'b1;
          end
          default: state <= ST_PRE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mdio_reg_file.sv
module mdio_reg_file
  import mdio_pkg::*;
#(
  parameter logic [DataW-1:0] ID_HI = 16'h2222,
  parameter logic [DataW-1:0] ID_LO = 16'h3333
) (
  input  logic             clk,
  input  logic             rst,
  input  mgmtCmd_t         cmd,
  input  logic             linkUp,
  input  logic             anComplete,
  input  logic             remoteFault,
  input  logic [DataW-1:0] partnerAbility,
  input  logic             pageReceived,
  output logic [DataW-1:0] rdData,
  output logic             pcsReset,
  output logic             pcsLoopback,
  output logic             anEnable,
  output logic             anRestart
);
  logic       ctlRst, ctlLoop, ctlAne, ctlRestart;
  logic [1:0] advPause;
  logic       linkLatch, rfLatch, pageLatch;
  logic       rdSts, rdExp, wrCtl, wrAdv;

  assign rdSts = cmd.rdStrobe && (cmd.regAddr == AddrSts);
  assign rdExp = cmd.rdStrobe && (cmd.regAddr == AddrExp);
  assign wrCtl = cmd.wrStrobe && (cmd.regAddr == AddrCtl);
  assign wrAdv = cmd.wrStrobe && (cmd.regAddr == AddrAdv);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctlRst     <= 1'b0;
      ctlLoop    <= 1'b0;
      ctlAne     <= 1'b0;
      ctlRestart <= 1'b0;
      advPause   <= 2'b00;
      linkLatch  <= 1'b0;
      rfLatch    <= 1'b0;
      pageLatch  <= 1'b0;
    end else begin
      ctlRst     <= 1'b0;
      ctlRestart <= 1'b0;
      if (wrCtl) begin
        if (cmd.wrData[15]) begin
          ctlRst   <= 1'b1;
          ctlLoop  <= 1'b0;
          ctlAne   <= 1'b0;
          advPause <= 2'b00;
        end else begin
          ctlLoop    <= cmd.wrData[14];
          ctlAne     <= cmd.wrData[12];
          ctlRestart <= cmd.wrData[9];
        end
      end
      if (wrAdv) advPause <= cmd.wrData[8:7];
      linkLatch <= rdSts ? linkUp      : (linkLatch & linkUp);
      rfLatch   <= rdSts ? remoteFault : (rfLatch | remoteFault);
      pageLatch <= rdExp ? pageReceived : (pageLatch | pageReceived);
    end
  end

  logic [DataW-1:0] ctlWord, stsWord, advWord, expWord;
  assign ctlWord = {ctlRst, ctlLoop, 1'b0, ctlAne, 2'b00, ctlRestart,
                    1'b1, 1'b0, 1'b1, 6'b0};
  assign stsWord = {7'b0, 1'b1, 2'b00, anComplete, rfLatch, 1'b1,
                    linkLatch, 1'b0, 1'b1};
  assign advWord = {7'b0, advPause, 1'b0, 1'b1, 5'b0};
  assign expWord = {14'b0, pageLatch, 1'b0};

  always_comb begin
    unique case (cmd.regAddr)
      AddrCtl:  rdData = ctlWord;
      AddrSts:  rdData = stsWord;
      AddrIdHi: rdData = ID_HI;
      AddrIdLo: rdData = ID_LO;
      AddrAdv:  rdData = advWord;
      AddrLpa:  rdData = partnerAbility;
      AddrExp:  rdData = expWord;
      AddrExt:  rdData = 16'h8000;
      default:  rdData = '0;
    endcase
  end

  logic unusedWrBits;
  assign unusedWrBits = ^{cmd.wrData[13], cmd.wrData[11:10], cmd.wrData[6:0]};

  assign pcsReset    = ctlRst;
  assign pcsLoopback = ctlLoop;
  assign anEnable    = ctlAne;
  assign anRestart   = ctlRestart;
endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave
  import mdio_pkg::*;
#(
  parameter int               PRE_LEN     = 32,
  parameter int               SYNC_STAGES = 2,
  parameter logic [DataW-1:0] ID_HI       = 16'h2222,
  parameter logic [DataW-1:0] ID_LO       = 16'h3333
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [PhyAddrW-1:0] phyAddr,
  input  logic                mdc,
  input  logic                mdioIn,
  output logic                mdioOut,
  output logic                mdioOe,
  output logic                pcsReset,
  output logic                pcsLoopback,
  output logic                anEnable,
  output logic                anRestart,
  input  logic                linkUp,
  input  logic                anComplete,
  input  logic                remoteFault,
  input  logic [DataW-1:0]    partnerAbility,
  input  logic                pageReceived
);
  mgmtCmd_t         cmd;
  logic [DataW-1:0] rdData;

  mdio_frame_ctrl #(.PRE_LEN(PRE_LEN), .SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk(clk), .rst(rst), .phyAddr(phyAddr), .mdc(mdc), .mdioIn(mdioIn),
    .rdData(rdData), .cmd(cmd), .mdioOut(mdioOut), .mdioOe(mdioOe)
  );

  mdio_reg_file #(.ID_HI(ID_HI), .ID_LO(ID_LO)) i_regs (
    .clk(clk), .rst(rst), .cmd(cmd), .linkUp(linkUp),
    .anComplete(anComplete), .remoteFault(remoteFault),
    .partnerAbility(partnerAbility), .pageReceived(pageReceived),
    .rdData(rdData), .pcsReset(pcsReset), .pcsLoopback(pcsLoopback),
    .anEnable(anEnable), .anRestart(anRestart)
  );
endmodule

// File: rtl/mdio_mgmt_checker.sv
module mdio_mgmt_checker (
  input logic clk,
  input logic rst,
  input logic mdioOut,
  input logic mdioOe,
  input logic pcsReset,
  input logic pcsLoopback,
  input logic anEnable,
  input logic anRestart
);
  AST_RESET_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    pcsReset |=> !pcsReset); // R4
  AST_RESET_RESTORES: assert property (@(posedge clk) disable iff (rst)
    pcsReset |-> (!pcsLoopback && !anEnable)); // R4
  AST_RESTART_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    anRestart |=> !anRestart); // R5
  AST_TA_DRIVES_ZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(mdioOe) |-> !mdioOut); // R2
  AST_RELEASED_LOW: assert property (@(posedge clk) disable iff (rst)
    !mdioOe |-> !mdioOut); // R2
endmodule

bind mdio_mgmt_slave mdio_mgmt_checker i_checker (
  .clk(clk), .rst(rst), .mdioOut(mdioOut), .mdioOe(mdioOe),
  .pcsReset(pcsReset), .pcsLoopback(pcsLoopback),
  .anEnable(anEnable), .anRestart(anRestart)
);

// File: tb/test_mdio_mgmt_slave.sv
module test_mdio_mgmt_slave;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  phyAddr = 5'h09;
  logic        mdc = 1'b0;
  logic        mdioM = 1'b1;
  logic        mdioIn;
  logic        mdioOut, mdioOe;
  logic        pcsReset, pcsLoopback, anEnable, anRestart;
  logic        linkUp = 1'b0, anComplete = 1'b0, remoteFault = 1'b0;
  logic [15:0] partnerAbility = 16'hA5C3;
  logic        pageReceived = 1'b0;

  int nChk = 0, nFail = 0;
  int rstPulses = 0, restartPulses = 0;
  logic [15:0] rd;
  logic [4:0]  fl;

  always #4 clk = ~clk;
  assign mdioIn = mdioOe ? mdioOut : mdioM;

  mdio_mgmt_slave i_mdio_mgmt_slave (
    .clk(clk), .rst(rst), .phyAddr(phyAddr), .mdc(mdc), .mdioIn(mdioIn),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .pcsReset(pcsReset),
    .pcsLoopback(pcsLoopback), .anEnable(anEnable), .anRestart(anRestart),
    .linkUp(linkUp), .anComplete(anComplete), .remoteFault(remoteFault),
    .partnerAbility(partnerAbility), .pageReceived(pageReceived)
  );

  always @(negedge clk) begin
    if (pcsReset)  rstPulses++;
    if (anRestart) restartPulses++;
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic sendBit(input logic b, output logic o, output logic e);
    @(negedge clk);
    mdc = 1'b0; mdioM = b;
    repeat (6) @(negedge clk);
    o = mdioOut; e = mdioOe;
    mdc = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  // flags: [0] oe in TA1, [1] oe in TA2, [2] out in TA2, [3] oe in all data bits, [4] oe after frame
  task automatic doFrame(input int preLen, input logic [1:0] op, input logic [4:0] pa,
                         input logic [4:0] ra, input logic [15:0] wd,
                         output logic [15:0] rdv, output logic [4:0] flags);
    logic o, e, dOe;
    dOe = 1'b1;
    for (int i = 0; i < preLen; i++) sendBit(1'b1, o, e);
    sendBit(1'b0, o, e); sendBit(1'b1, o, e);
    for (int i = 1; i >= 0; i--) sendBit(op[i], o, e);
    for (int i = 4; i >= 0; i--) sendBit(pa[i], o, e);
    for (int i = 4; i >= 0; i--) sendBit(ra[i], o, e);
    sendBit(1'b1, o, e); flags[0] = e;
    sendBit(op == 2'b01 ? 1'b0 : 1'b1, o, e); flags[1] = e; flags[2] = o;
    for (int i = 15; i >= 0; i--) begin
      sendBit(wd[i], o, e); rdv[i] = o; dOe = dOe & e;
    end
    flags[3] = dOe;
    sendBit(1'b1, o, e); flags[4] = e;
  endtask

  task automatic rdReg(input logic [4:0] ra, output logic [15:0] v);
    logic [4:0] f;
    doFrame(32, 2'b10, phyAddr, ra, 16'h0, v, f);
  endtask

  task automatic wrReg(input logic [4:0] ra, input logic [15:0] v);
    logic [15:0] d; logic [4:0] f;
    doFrame(32, 2'b01, phyAddr, ra, v, d, f);
  endtask

  function automatic logic [15:0] expIdle(input logic [4:0] a);
    case (a)
      5'd0: return 16'h0140;
      5'd1: return 16'h0109;
      5'd2: return 16'h2222;
      5'd3: return 16'h3333;
      5'd4: return 16'h0020;
      5'd5: return partnerAbility;
      5'd15: return 16'h8000;
      default: return 16'h0000;
    endcase
  endfunction

  initial begin
    repeat (190000) @(negedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R3 reset outputs", {12'b0, pcsLoopback, anEnable, pcsReset, anRestart}, 16'h0);
    chk("R2 idle release", {15'b0, mdioOe}, 16'h0);

    // R2: read framing of control
    doFrame(32, 2'b10, phyAddr, 5'd0, 16'h0, rd, fl);
    chk("R3 control default", rd, 16'h0140);
    chk("R2 turnaround/release flags", {11'b0, fl}, 16'h000A);

    // R9 R11 R6: sweep of every address from reset state
    for (int a = 0; a < 32; a++) begin
      rdReg(5'(a), rd);
      chk($sformatf("R11 sweep addr %0d", a), rd, expIdle(5'(a)));
    end

    // R1: foreign PHY address
    doFrame(32, 2'b10, 5'h0A, 5'd2, 16'h0, rd, fl);
    chk("R1 foreign read never drives", {11'b0, fl}, 16'h0);
    doFrame(32, 2'b01, 5'h0A, 5'd0, 16'h5000, rd, fl);
    rdReg(5'd0, rd);
    chk("R1 foreign write ignored", rd, 16'h0140);

    // R3 R5: writable control fields, restart pulse
    wrReg(5'd0, 16'h7FFF);
    rdReg(5'd0, rd);
    chk("R3 control readback", rd, 16'h5140);
    chk("R3 loopback/ane outputs", {14'b0, pcsLoopback, anEnable}, 16'h0003);
    chk("R5 restart pulse count", 16'(restartPulses), 16'd1);
    wrReg(5'd0, 16'h4000);
    rdReg(5'd0, rd);
    chk("R3 control partial write", rd, 16'h4140);
    chk("R5 no pulse without bit 9", 16'(restartPulses), 16'd1);

    // R10: advertisement
    wrReg(5'd4, 16'hFFFF);
    rdReg(5'd4, rd);
    chk("R10 pause writable", rd, 16'h01A0);

    // R4: soft reset
    wrReg(5'd0, 16'hFFFF);
    chk("R4 reset pulse count", 16'(rstPulses), 16'd1);
    rdReg(5'd0, rd);
    chk("R4 control restored", rd, 16'h0140);
    rdReg(5'd4, rd);
    chk("R4 pause restored", rd, 16'h0020);
    chk("R4 outputs cleared", {14'b0, pcsLoopback, anEnable}, 16'h0);

    // R6 R7: status writes ignored, link latching low
    wrReg(5'd1, 16'hFFFF);
    linkUp = 1'b1;
    rdReg(5'd1, rd);
    chk("R7 latched low before reload", rd, 16'h0109);
    rdReg(5'd1, rd);
    chk("R6 R7 status after reload", rd, 16'h010D);
    linkUp = 1'b0; repeat (20) @(negedge clk); linkUp = 1'b1;
    rdReg(5'd1, rd);
    chk("R7 link drop held", rd, 16'h0109);
    rdReg(5'd1, rd);
    chk("R7 link recovered", rd, 16'h010D);

    // R8: remote fault latches high, completion live
    remoteFault = 1'b1; repeat (20) @(negedge clk); remoteFault = 1'b0;
    rdReg(5'd1, rd);
    chk("R8 fault held", rd, 16'h011D);
    rdReg(5'd1, rd);
    chk("R8 fault cleared by read", rd, 16'h010D);
    anComplete = 1'b1;
    rdReg(5'd1, rd);
    chk("R8 complete live high", rd, 16'h012D);
    anComplete = 1'b0;
    rdReg(5'd1, rd);
    chk("R8 complete live low", rd, 16'h010D);

    // R11: page received, live partner word
    pageReceived = 1'b1; repeat (20) @(negedge clk); pageReceived = 1'b0;
    rdReg(5'd6, rd);
    chk("R11 page latched", rd, 16'h0002);
    rdReg(5'd6, rd);
    chk("R11 page cleared", rd, 16'h0000);
    partnerAbility = 16'h1E5A;
    rdReg(5'd5, rd);
    chk("R11 partner live", rd, 16'h1E5A);

    // R12: illegal opcodes and short preamble
    doFrame(32, 2'b11, phyAddr, 5'd0, 16'h5000, rd, fl);
    doFrame(32, 2'b00, phyAddr, 5'd0, 16'h5000, rd, fl);
    rdReg(5'd0, rd);
    chk("R12 bad opcodes ignored", rd, 16'h0140);
    doFrame(20, 2'b01, phyAddr, 5'd0, 16'h5000, rd, fl);
    rdReg(5'd0, rd);
    chk("R12 short preamble ignored", rd, 16'h0140);
    chk("R12 outputs unchanged", {14'b0, pcsLoopback, anEnable}, 16'h0);

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule